// File: doc/BRIEF.md
# Edge-Directed Line Interpolator

This block produces one missing pixel that lies between two existing video lines. It is used for deinterlacing or vertical upscaling. For every output pixel it takes a three-pixel window from the line above and a three-pixel window from the line below. It then considers three straight pairings through the missing position: falling diagonal, vertical and rising diagonal. Averaging along the direction where the two pixels look most alike keeps slanted edges sharp. A blind vertical average would turn them into stairs.

The likeness of a pair is measured as the absolute difference divided by the pair's brightness plus one. A given step in dark areas therefore counts as more visible than the same step in bright areas. The comparison never divides: the two ratios are compared by cross-multiplication. Samples enter on a valid-qualified stream. The result leaves two clock cycles later with its own valid flag.

Top module: `dli_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is 0 and `out_pix` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles.
- R3: The output is floor((a+b)/2) of the chosen pair, computed without overflow, so two inputs of 255 give 255.
- R4: Each pair's weight is |a-b| / (a+b+1). The pair with the smallest weight is chosen, even when another pair has a smaller plain absolute difference.
- R5: When the pairs have equal absolute differences, the brighter pair has the smaller weight and is chosen.
- R6: On a weight tie that involves the vertical pair (`up_c`,`dn_c`), the vertical pair wins.
- R7: On a tie between the two diagonals only, the falling pair (`up_l`,`dn_r`) wins over the rising pair (`up_r`,`dn_l`).
- R8: When `out_valid` is 0, `out_pix` keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window inputs are valid this cycle |
| up_l | input | 8 | Upper line, left neighbour |
| up_c | input | 8 | Upper line, centre |
| up_r | input | 8 | Upper line, right neighbour |
| dn_l | input | 8 | Lower line, left neighbour |
| dn_c | input | 8 | Lower line, centre |
| dn_r | input | 8 | Lower line, right neighbour |
| out_valid | output | 1 | Interpolated pixel is valid |
| out_pix | output | 8 | Interpolated pixel |

## Verification
The bench targets the following corner cases:

- Full-scale pairs. A design that drops the ninth bit of the sum returns 127 instead of 255.
- A bright pair with a large difference facing a dark pair with a small difference. A design that ranks on raw difference averages the wrong pair.
- Exact ratio ties such as 1/4 against 3/12, together with zero-difference ties. A wrong priority order produces a visibly different average.
- Valid bubbles. These expose a stage that updates the output on idle cycles or shifts the valid flag by a cycle.

// File: rtl/dli_pkg.sv
package dli_pkg;
  // candidate order doubles as tie priority: lower index wins
  localparam int unsigned NUM_PAIRS = 3;
  typedef enum logic [1:0] {
    PAIR_VERT = 2'd0,
    PAIR_FALL = 2'd1,
    PAIR_RISE = 2'd2
  } pair_e;
endpackage

// File: rtl/dli_pair_metric.sv
module dli_pair_metric #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [PIX_W-1:0] absd,
  output logic [PIX_W:0]   sum,
  output logic [PIX_W:0]   den
);
  always_comb begin
    absd = (a > b) ? (a - b) : (b - a);
    sum  = {1'b0, a} + {1'b0, b};
    // a+b+1 never exceeds 2^(PIX_W+1)-1
    den  = sum + 1'b1;
  end
endmodule

// File: rtl/dli_select.sv
module dli_select
  import dli_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] absd [NUM_PAIRS],
  input  logic [PIX_W:0]   den  [NUM_PAIRS],
  input  logic [PIX_W:0]   sum  [NUM_PAIRS],
  output logic [PIX_W-1:0] avg
);
  localparam int unsigned PROD_W = 2 * PIX_W + 1;

  logic [PROD_W-1:0] lhs, rhs;
  logic [PIX_W:0]    best_sum;
  logic [PIX_W-1:0]  best_absd;
  logic [PIX_W:0]    best_den;

  always_comb begin
    best_sum  = sum[0];
    best_absd = absd[0];
    best_den  = den[0];
    lhs       = '0;
    rhs       = '0;
    for (int k = 1; k < NUM_PAIRS; k++) begin
      // absd[k]/den[k] < best_absd/best_den, cross-multiplied
      lhs = {{(PIX_W+1){1'b0}}, absd[k]} * {{PIX_W{1'b0}}, best_den};
      rhs = {{(PIX_W+1){1'b0}}, best_absd} * {{PIX_W{1'b0}}, den[k]};
      if (lhs < rhs) begin
        best_sum  = sum[k];
        best_absd = absd[k];
        best_den  = den[k];
      end
    end
    avg = best_sum[PIX_W:1];
  end
endmodule

// File: rtl/dli_top.sv
module dli_top
  import dli_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] up_l,
  input  logic [PIX_W-1:0] up_c,
  input  logic [PIX_W-1:0] up_r,
  input  logic [PIX_W-1:0] dn_l,
  input  logic [PIX_W-1:0] dn_c,
  input  logic [PIX_W-1:0] dn_r,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic [PIX_W-1:0] pa [NUM_PAIRS];
  logic [PIX_W-1:0] pb [NUM_PAIRS];
  logic [PIX_W-1:0] c_absd [NUM_PAIRS];
  logic [PIX_W:0]   c_sum  [NUM_PAIRS];
  logic [PIX_W:0]   c_den  [NUM_PAIRS];
  logic [PIX_W-1:0] s1_absd [NUM_PAIRS];
  logic [PIX_W:0]   s1_sum  [NUM_PAIRS];
  logic [PIX_W:0]   s1_den  [NUM_PAIRS];
  logic             s1_valid;
  logic [PIX_W-1:0] sel_avg;

  always_comb begin
    pa[PAIR_VERT] = up_c;  pb[PAIR_VERT] = dn_c;
    pa[PAIR_FALL] = up_l;  pb[PAIR_FALL] = dn_r;
    pa[PAIR_RISE] = up_r;  pb[PAIR_RISE] = dn_l;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    dli_pair_metric #(.PIX_W(PIX_W)) u_metric (
      .a    (pa[g]),
      .b    (pb[g]),
      .absd (c_absd[g]),
      .sum  (c_sum[g]),
      .den  (c_den[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_absd[g] <= '0;
        s1_sum[g]  <= '0;
        s1_den[g]  <= '0;
      end else if (in_valid) begin
        s1_absd[g] <= c_absd[g];
        s1_sum[g]  <= c_sum[g];
        s1_den[g]  <= c_den[g];
      end
    end
  end

  dli_select #(.PIX_W(PIX_W)) u_select (
    .absd (s1_absd),
    .den  (s1_den),
    .sum  (s1_sum),
    .avg  (sel_avg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= sel_avg;
    end
  end
endmodule

// File: rtl/dli_checker.sv
module dli_checker #(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [PIX_W-1:0] up_l,
  input logic [PIX_W-1:0] up_c,
  input logic [PIX_W-1:0] up_r,
  input logic [PIX_W-1:0] dn_l,
  input logic [PIX_W-1:0] dn_c,
  input logic [PIX_W-1:0] dn_r,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  logic [PIX_W-1:0] lo6, hi6, av_v, av_f, av_r;
  logic [PIX_W:0]   t_v, t_f, t_r;

  always_comb begin
    lo6 = up_l;
    hi6 = up_l;
    if (up_c < lo6) lo6 = up_c;
    if (up_r < lo6) lo6 = up_r;
    if (dn_l < lo6) lo6 = dn_l;
    if (dn_c < lo6) lo6 = dn_c;
    if (dn_r < lo6) lo6 = dn_r;
    if (up_c > hi6) hi6 = up_c;
    if (up_r > hi6) hi6 = up_r;
    if (dn_l > hi6) hi6 = dn_l;
    if (dn_c > hi6) hi6 = dn_c;
    if (dn_r > hi6) hi6 = dn_r;
    t_v  = ({1'b0, up_c} + {1'b0, dn_c}) >> 1;
    t_f  = ({1'b0, up_l} + {1'b0, dn_r}) >> 1;
    t_r  = ({1'b0, up_r} + {1'b0, dn_l}) >> 1;
    av_v = t_v[PIX_W-1:0];
    av_f = t_f[PIX_W-1:0];
    av_r = t_r[PIX_W-1:0];
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_pix));
  assert_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pix >= $past(lo6, 2) && out_pix <= $past(hi6, 2)));
  assert_pair_avg_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pix == $past(av_v, 2) || out_pix == $past(av_f, 2)
                   || out_pix == $past(av_r, 2)));
  assert_flat_vert_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && up_c == dn_c) |-> ##2 (out_pix == $past(up_c, 2)));
endmodule

bind dli_top dli_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .up_l(up_l), .up_c(up_c), .up_r(up_r),
  .dn_l(dn_l), .dn_c(dn_c), .dn_r(dn_r),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/test_dli_top.sv
module test_dli_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] up_l = '0, up_c = '0, up_r = '0;
  logic [7:0] dn_l = '0, dn_c = '0, dn_r = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  int nvec = 0;
  int nfail = 0;

  // reference pipeline state
  bit    m1_v = 0;
  int    m1_pix = 0;
  string m1_tag = "R1";
  bit    m_ov = 0;
  int    m_op = 0;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dli_top i_dli_top (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .up_l(up_l), .up_c(up_c), .up_r(up_r),
    .dn_l(dn_l), .dn_c(dn_c), .dn_r(dn_r),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic real wgt(int a, int b);
    int d = (a > b) ? a - b : b - a;
    return real'(d) / real'(a + b + 1);
  endfunction

  // vertical first, then falling, then rising; strict less keeps priority
  function automatic int ref_pix(int ul, int uc, int ur, int dl, int dc, int dr);
    real bw = wgt(uc, dc);
    int  bs = uc + dc;
    if (wgt(ul, dr) < bw) begin bw = wgt(ul, dr); bs = ul + dr; end
    if (wgt(ur, dl) < bw) begin bw = wgt(ur, dl); bs = ur + dl; end
    return bs / 2;
  endfunction

  task automatic step(input bit v, input int ul, input int uc, input int ur,
                      input int dl, input int dc, input int dr, input string tag);
    in_valid = v;
    up_l = 8'(ul); up_c = 8'(uc); up_r = 8'(ur);
    dn_l = 8'(dl); dn_c = 8'(dc); dn_r = 8'(dr);
    @(posedge clk);
    m_ov = m1_v;
    if (m1_v) begin m_op = m1_pix; m_tag = m1_tag; end
    else m_tag = "R8";
    m1_v = v;
    if (v) begin m1_pix = ref_pix(ul, uc, ur, dl, dc, dr); m1_tag = tag; end
    @(negedge clk);
    nvec++;
    if (out_valid !== m_ov || out_pix !== 8'(m_op)) begin
      nfail++;
      $display("FAIL %s: out_valid=%0b out_pix=%0d, expected out_valid=%0b out_pix=%0d",
               m_tag, out_valid, out_pix, m_ov, m_op);
    end
  endtask

  task automatic flush();
    for (int k = 0; k < 3; k++) step(1'b0, 0, 0, 0, 0, 0, 0, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nvec++;
    if (out_valid !== 1'b0 || out_pix !== 8'd0) begin
      nfail++;
      $display("FAIL R1: out_valid=%0b out_pix=%0d, expected 0 0", out_valid, out_pix);
    end
    rst = 1'b0;
    step(1'b0, 0, 0, 0, 0, 0, 0, "R1");

    // R3: full scale keeps the carry -> 255
    step(1'b1, 255, 255, 255, 255, 255, 255, "R3");
    // R3: odd sum floors: vertical (254,255) -> 254
    step(1'b1, 0, 254, 9, 200, 255, 100, "R3");
    flush();
    // R4: vertical (0,5) w=5/6 loses to falling (100,120) w=20/221 -> 110
    step(1'b1, 100, 0, 0, 255, 5, 120, "R4");
    // R5: equal diff 10; dark vertical (20,30), bright falling (200,210) -> 205
    step(1'b1, 200, 20, 100, 110, 30, 210, "R5");
    // R6: all zero-diff; vertical 40 wins over 90 and 7
    step(1'b1, 90, 40, 7, 7, 40, 90, "R6");
    // R6: ratio tie 1/4 vertical (1,2) vs falling (4,7) -> 1
    step(1'b1, 4, 1, 0, 200, 2, 7, "R6");
    // R7: diagonal tie 1/4 falling (1,2) vs rising (4,7), vertical (0,100) -> 1
    step(1'b1, 1, 0, 4, 7, 100, 2, "R7");
    // R7: zero-diff diagonals 30 vs 60, vertical (0,255) -> 30
    step(1'b1, 30, 0, 60, 60, 255, 30, "R7");
    // R8: bubbles with changing data must not move the output
    step(1'b0, 1, 2, 3, 4, 5, 6, "R8");
    step(1'b0, 250, 3, 9, 77, 1, 0, "R8");
    step(1'b1, 10, 20, 30, 40, 50, 60, "R2");
    step(1'b0, 9, 9, 9, 9, 9, 9, "R8");
    flush();

    // R2 R4 R8: mixed stream with bubbles
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 4) != 0,
           int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 256), int'($urandom % 256), int'($urandom % 256), "R4");
    end
    // R5: dark-heavy stream where luminance scaling matters most
    for (int n = 0; n < 200; n++) begin
      step(1'b1,
           int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
           int'($urandom % 16), int'($urandom % 16), int'($urandom % 16), "R5");
    end
    flush();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule